// File: doc/BRIEF.md
# Tiled Surface Parameter Checker

This block decides whether a request to retile a graphics surface can be honoured. Each request carries a generation code, a tiling mode, a row stride, the object size and the object's current placement (offset and allocated size), plus the unfenced alignment that applies to the object. For each request the block returns three verdicts. The legal flag says whether the stride and size are acceptable for the tiling mode. The fence-compatible flag says whether the current placement can be covered by a fence register. The unbind-required flag says whether the object must be moved before the new tiling takes effect.

Requests enter on a valid/ready port and verdicts leave on a valid/ready port, two register stages later. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. A verdict is handed over on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the verdict on the output stays put and the pipeline fills. Once both stages hold data, `in_ready` falls. Verdicts leave in the order their requests arrived. None is dropped or duplicated.

Encodings. Tiling mode: 2'b00 linear, 2'b01 X-tiled, 2'b10 Y-tiled, 2'b11 reserved. Generation: bit 1 set means a newer part. 2'b00 is the older part with a 2^19-byte fence granule. 2'b01 is the older part with a 2^20-byte fence granule. The X tile width is `X_TILE_W` bytes. The Y tile width is 128 bytes when `Y_NARROW` is 1 and `X_TILE_W` otherwise.

Top module: `tile_param_checker`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: A linear request (mode 2'b00) yields legal=1, fence=1 and unbind=0 for every generation, stride, size and placement.
- R3: On a newer part (gen bit 1 set), a tiled request is illegal when stride>>7 exceeds `PITCH_MAX`. The object size is never checked on a newer part.
- R4: On a newer part, a tiled request is illegal unless the stride is a whole multiple of the tile width (X: `X_TILE_W`; Y: 128 when `Y_NARROW`=1).
- R5: On an older part, a tiled request is illegal unless the stride is at least the tile width and is a power of two.
- R6: On an older part, a tiled request is illegal when the object size exceeds `SIZE_FIELD`<<19 (gen 2'b00) or `SIZE_FIELD`<<20 (gen 2'b01).
- R7: On a newer part, every X or Y request is fence-compatible.
- R8: On an older part, an X or Y request is fence-compatible only if the offset has no set bits outside the window [S, S+`MASK_BITS`-1]. S is 19 for gen 2'b00 and 20 for gen 2'b01.
- R9: On an older part, an X or Y request is fence-compatible only if the placement size equals F and the offset is a multiple of F. F is the smallest power of two that is at least 2^S and at least the object size.
- R10: unbind=1 exactly when fence=0 and the offset has a set bit below the unfenced alignment (a power of two).
- R11: Mode 2'b11 yields legal=0 and fence=0.
- R12: With `out_ready` held high, a verdict appears two cycles after its request is taken. A stalled verdict holds its value. Verdicts leave in request order. With both stages full and the output stalled, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_gen | input | 2 | Generation code |
| in_mode | input | 2 | Tiling mode code |
| in_stride | input | SW | Row stride in bytes |
| in_obj_size | input | AW | Object size in bytes |
| in_place_off | input | AW | Current placement offset |
| in_place_size | input | AW | Current placement size |
| in_unfenced_align | input | AW | Unfenced alignment, power of two |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Verdict can be taken |
| out_legal | output | 1 | Stride and size acceptable |
| out_fence_ok | output | 1 | Placement is fence-compatible |
| out_unbind | output | 1 | Object must be moved |

## Verification
The bench builds the block with `PITCH_MAX`=8, `SIZE_FIELD`=4, `SW`=16 and `Y_NARROW`=1. With these values the pitch ceiling sits at strides 1024 (accepted) and 1152 (rejected). The older-part size ceilings drop to 2 MiB and 4 MiB, so both sides of each boundary can be reached with small operands. Random back-pressure on `out_ready` runs alongside directed and randomized requests, so stall, fill and in-order draining are all exercised.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic [1:0] {
    MODE_LIN = 2'b00,
    MODE_X   = 2'b01,
    MODE_Y   = 2'b10,
    MODE_RSV = 2'b11
  } tile_mode_e;

  // gen[1] : newer part; gen[0] : older variant with the larger fence granule
  localparam int GEN_NEW_BIT   = 1;
  localparam int GEN_LARGE_BIT = 0;
endpackage

// File: rtl/tpc_stage.sv
module tpc_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

  // R12: a held word must not change
  p_stage_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
endmodule

// File: rtl/tpc_legal.sv
module tpc_legal
  import tpc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SW         = 18,
  parameter int PITCH_MAX  = 1023,
  parameter int SIZE_FIELD = 32,
  parameter int SHIFT_A    = 19,
  parameter int SHIFT_B    = 20,
  parameter int X_TILE_W   = 512,
  parameter bit Y_NARROW   = 1'b1
) (
  input  logic [1:0]    gen,
  input  logic [1:0]    mode,
  input  logic [SW-1:0] stride,
  input  logic [AW-1:0] obj_size,
  output logic          legal
);
  localparam logic [AW-1:0] LIM_A = AW'(SIZE_FIELD) << SHIFT_A;
  localparam logic [AW-1:0] LIM_B = AW'(SIZE_FIELD) << SHIFT_B;
  localparam logic [SW-1:0] TW_X  = SW'(X_TILE_W);
  localparam logic [SW-1:0] TW_Y  = Y_NARROW ? SW'(128) : SW'(X_TILE_W);

  logic [SW-1:0] tw;
  logic          new_ok, old_ok, pow2, size_ok;

  always_comb begin
    tw      = (mode == MODE_Y) ? TW_Y : TW_X;
    new_ok  = ((32'(stride) >> 7) <= 32'(PITCH_MAX)) &&
              ((stride & (tw - SW'(1))) == '0);
    pow2    = (stride != '0) && ((stride & (stride - SW'(1))) == '0);
    size_ok = obj_size <= (gen[GEN_LARGE_BIT] ? LIM_B : LIM_A);
    old_ok  = (stride >= tw) && pow2 && size_ok;
    unique case (mode)
      MODE_LIN: legal = 1'b1;
      MODE_RSV: legal = 1'b0;
      default:  legal = gen[GEN_NEW_BIT] ? new_ok : old_ok;
    endcase
  end
endmodule

// File: rtl/tpc_fence_prep.sv
module tpc_fence_prep
  import tpc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SHIFT_A   = 19,
  parameter int SHIFT_B   = 20,
  parameter int MASK_BITS = 8
) (
  input  logic [1:0]    gen,
  input  logic [AW-1:0] obj_size,
  input  logic [AW-1:0] place_off,
  output logic [AW-1:0] fence_size,
  output logic          window_ok
);
  localparam logic [AW-1:0] WIN   = (AW'(1) << MASK_BITS) - AW'(1);
  localparam logic [AW-1:0] MSK_A = WIN << SHIFT_A;
  localparam logic [AW-1:0] MSK_B = WIN << SHIFT_B;
  localparam logic [AW-1:0] TOP   = AW'(1) << (AW - 1);

  logic [AW-1:0] fsz;

  always_comb begin
    fsz = gen[GEN_LARGE_BIT] ? (AW'(1) << SHIFT_B) : (AW'(1) << SHIFT_A);
    for (int i = 0; i < AW; i++) begin
      if (fsz < obj_size && fsz != TOP) fsz = fsz << 1;
    end
    fence_size = fsz;
    window_ok  = (place_off & ~(gen[GEN_LARGE_BIT] ? MSK_B : MSK_A)) == '0;
  end
endmodule

// File: rtl/tile_param_checker.sv
module tile_param_checker
  import tpc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SW         = 18,
  parameter int PITCH_MAX  = 1023,
  parameter int SIZE_FIELD = 32,
  parameter int SHIFT_A    = 19,
  parameter int SHIFT_B    = 20,
  parameter int MASK_BITS  = 8,
  parameter int X_TILE_W   = 512,
  parameter bit Y_NARROW   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_gen,
  input  logic [1:0]    in_mode,
  input  logic [SW-1:0] in_stride,
  input  logic [AW-1:0] in_obj_size,
  input  logic [AW-1:0] in_place_off,
  input  logic [AW-1:0] in_place_size,
  input  logic [AW-1:0] in_unfenced_align,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_legal,
  output logic          out_fence_ok,
  output logic          out_unbind
);
  typedef struct packed {
    logic          legal;
    logic          lin;
    logic          rsv;
    logic          newer;
    logic          win_ok;
    logic [AW-1:0] fsz;
    logic [AW-1:0] off;
    logic [AW-1:0] psize;
    logic [AW-1:0] align;
  } s1_t;

  localparam int S1W = $bits(s1_t);

  s1_t           s1_d, s1_q;
  logic          s1_valid, s1_ready;
  logic          legal_c, win_c;
  logic [AW-1:0] fsz_c;
  logic          fence_c, unbind_c;
  logic [2:0]    s2_d, s2_q;

  tpc_legal #(
    .AW(AW), .SW(SW), .PITCH_MAX(PITCH_MAX), .SIZE_FIELD(SIZE_FIELD),
    .SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B), .X_TILE_W(X_TILE_W), .Y_NARROW(Y_NARROW)
  ) u_legal (
    .gen(in_gen), .mode(in_mode), .stride(in_stride),
    .obj_size(in_obj_size), .legal(legal_c)
  );

  tpc_fence_prep #(
    .AW(AW), .SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B), .MASK_BITS(MASK_BITS)
  ) u_fprep (
    .gen(in_gen), .obj_size(in_obj_size), .place_off(in_place_off),
    .fence_size(fsz_c), .window_ok(win_c)
  );

  always_comb begin
    s1_d.legal  = legal_c;
    s1_d.lin    = (in_mode == MODE_LIN);
    s1_d.rsv    = (in_mode == MODE_RSV);
    s1_d.newer  = in_gen[GEN_NEW_BIT];
    s1_d.win_ok = win_c;
    s1_d.fsz    = fsz_c;
    s1_d.off    = in_place_off;
    s1_d.psize  = in_place_size;
    s1_d.align  = in_unfenced_align;
  end

  tpc_stage #(.W(S1W)) u_s1 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(s1_d),
    .dn_valid(s1_valid), .dn_ready(s1_ready), .dn_data(s1_q)
  );

  // stage 2: placement verdicts
  always_comb begin
    if (s1_q.lin)        fence_c = 1'b1;
    else if (s1_q.rsv)   fence_c = 1'b0;
    else if (s1_q.newer) fence_c = 1'b1;
    else                 fence_c = s1_q.win_ok && (s1_q.psize == s1_q.fsz) &&
                                   ((s1_q.off & (s1_q.fsz - AW'(1))) == '0);
    unbind_c = !fence_c && ((s1_q.off & (s1_q.align - AW'(1))) != '0);
    s2_d     = {s1_q.legal, fence_c, unbind_c};
  end

  tpc_stage #(.W(3)) u_s2 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(s1_valid), .up_ready(s1_ready), .up_data(s2_d),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(s2_q)
  );

  assign {out_legal, out_fence_ok, out_unbind} = s2_q;

  // R1: reset empties the output stage
  p_reset_empty_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);
  // R2: a linear request moving into stage 2 produces a clean verdict
  p_linear_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_ready && s1_q.lin |=> out_legal && out_fence_ok && !out_unbind);
  // R7: newer tiled requests are always fence-compatible
  p_newer_fence_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_ready && s1_q.newer && !s1_q.rsv |=> out_fence_ok && !out_unbind);
  // R10: unbind never accompanies a fence-compatible verdict
  p_unbind_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_unbind && out_fence_ok));
  // R12: the output holds while stalled
  p_out_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_legal, out_fence_ok, out_unbind}));
endmodule

// File: tb/tile_param_checker_bench.sv
module tile_param_checker_bench;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int PMAX = 8;
  localparam int SFIELD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_gen = '0;
  logic [1:0]    in_mode = '0;
  logic [SW-1:0] in_stride = '0;
  logic [AW-1:0] in_obj_size = '0;
  logic [AW-1:0] in_place_off = '0;
  logic [AW-1:0] in_place_size = '0;
  logic [AW-1:0] in_unfenced_align = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_legal, out_fence_ok, out_unbind;

  int checks = 0;
  int fails = 0;
  int bp_mode = 0;  // 0 ready, 1 stalled, 2 random
  bit finished = 0;

  typedef struct {
    logic [2:0] v;
    string      tag;
  } exp_t;
  exp_t sb[$];

  tile_param_checker #(
    .AW(AW), .SW(SW), .PITCH_MAX(PMAX), .SIZE_FIELD(SFIELD), .Y_NARROW(1'b1)
  ) u_tile_param_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_gen(in_gen), .in_mode(in_mode), .in_stride(in_stride),
    .in_obj_size(in_obj_size), .in_place_off(in_place_off),
    .in_place_size(in_place_size), .in_unfenced_align(in_unfenced_align),
    .out_valid(out_valid), .out_ready(out_ready), .out_legal(out_legal),
    .out_fence_ok(out_fence_ok), .out_unbind(out_unbind)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic [1:0] g, input logic [1:0] m,
      input int unsigned s, input logic [31:0] sz, input logic [31:0] off,
      input logic [31:0] ps, input logic [31:0] al);
    logic lg, fc, ub;
    int unsigned tw, sh;
    logic [31:0] f;
    tw = (m == 2'b10) ? 128 : 512;
    sh = g[0] ? 20 : 19;
    lg = 1'b0;
    fc = 1'b0;
    if (m == 2'b00) begin
      lg = 1'b1; fc = 1'b1;
    end else if (m == 2'b11) begin
      lg = 1'b0; fc = 1'b0;
    end else if (g[1]) begin
      lg = (s / 128 <= PMAX) && (s % tw == 0);
      fc = 1'b1;
    end else begin
      lg = (s >= tw) && ((s & (s - 1)) == 0) && (sz <= (32'(SFIELD) << sh));
      f = 32'd1 << sh;
      while (f < sz && f != 32'h8000_0000) f = f << 1;
      fc = ((off & ~(32'hFF << sh)) == 0) && (ps == f) && ((off & (f - 1)) == 0);
    end
    ub = !fc && ((off & (al - 1)) != 0);
    return {lg, fc, ub};
  endfunction

  task automatic send(input logic [1:0] g, input logic [1:0] m, input int unsigned s,
      input logic [31:0] sz, input logic [31:0] off, input logic [31:0] ps,
      input logic [31:0] al, input string tag);
    exp_t e;
    @(negedge clk);
    in_gen = g; in_mode = m; in_stride = SW'(s); in_obj_size = sz;
    in_place_off = off; in_place_size = ps; in_unfenced_align = al;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e.v = model(g, m, s, sz, off, ps, al);
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (bp_mode == 0) out_ready = 1'b1;
    else if (bp_mode == 1) out_ready = 1'b0;
    else out_ready = ($urandom % 4) != 0;
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R12 unexpected verdict", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({out_legal, out_fence_ok, out_unbind} == e.v, e.tag,
                int'({out_legal, out_fence_ok, out_unbind}), int'(e.v));
        end
      end
    end
  end

  task automatic drain();
    int n = 0;
    while ((sb.size() != 0 || out_valid) && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(sb.size() == 0, "R12 drain", sb.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R12 latency with ready held high
    send(2'b10, 2'b01, 1024, 32'h1000, 0, 0, 32'h1000, "R12 latency item");
    @(negedge clk);
    check(out_valid == 1'b0, "R12 not yet after one cycle", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R12 valid after two cycles", out_valid, 1);
    drain();

    // R2 linear
    send(2'b00, 2'b00, 3, 32'hFFFF_FFFF, 32'h1234_5677, 5, 32'h1000, "R2 linear older");
    send(2'b10, 2'b00, 7, 32'h10, 32'h3, 0, 32'h1000, "R2 linear newer");
    // R3 pitch ceiling, no size check on newer
    send(2'b10, 2'b10, 1024, 32'hFFFF_0000, 0, 0, 32'h1000, "R3 pitch at limit, huge size");
    send(2'b10, 2'b10, 1152, 32'h1000, 0, 0, 32'h1000, "R3 pitch above limit");
    // R4 tile-width multiple
    send(2'b10, 2'b01, 640, 32'h1000, 0, 0, 32'h1000, "R4 X not multiple of 512");
    send(2'b10, 2'b10, 640, 32'h1000, 0, 0, 32'h1000, "R4 Y multiple of 128");
    send(2'b11, 2'b01, 512, 32'h1000, 0, 0, 32'h1000, "R4 X exact tile width");
    // R5 older stride rules
    send(2'b00, 2'b01, 256, 32'h1000, 0, 32'h80000, 32'h1000, "R5 X below tile width");
    send(2'b00, 2'b10, 256, 32'h1000, 0, 32'h80000, 32'h1000, "R5 Y power of two");
    send(2'b00, 2'b10, 384, 32'h1000, 0, 32'h80000, 32'h1000, "R5 Y not power of two");
    // R6 older size limits
    send(2'b00, 2'b01, 512, 32'h20_0000, 0, 32'h20_0000, 32'h1000, "R6 small at limit");
    send(2'b00, 2'b01, 512, 32'h20_0001, 0, 32'h40_0000, 32'h1000, "R6 small above limit");
    send(2'b01, 2'b01, 512, 32'h40_0000, 0, 32'h40_0000, 32'h1000, "R6 large at limit");
    send(2'b01, 2'b01, 512, 32'h40_0001, 0, 32'h80_0000, 32'h1000, "R6 large above limit");
    // R7 newer fence, with odd placement
    send(2'b10, 2'b01, 1024, 32'h1000, 32'h0000_0123, 32'h7, 32'h1000, "R7 newer fence any placement");
    // R8 window
    send(2'b00, 2'b01, 512, 32'h1000, 32'h0000_1000 | 32'h80000, 32'h80000, 32'h1000, "R8 low bit outside window");
    send(2'b00, 2'b01, 512, 32'h1000, 32'h1000_0000, 32'h80000, 32'h1000, "R8 high bit outside window");
    send(2'b01, 2'b01, 512, 32'h1000, 32'h0FF0_0000, 32'h10_0000, 32'h1000, "R8 top of large window");
    // R9 fence size and alignment
    send(2'b00, 2'b10, 128, 32'h9_6000, 32'h10_0000, 32'h10_0000, 32'h1000, "R9 rounded to 1M aligned");
    send(2'b00, 2'b10, 128, 32'h9_6000, 32'h08_0000, 32'h10_0000, 32'h1000, "R9 misaligned offset");
    send(2'b00, 2'b10, 128, 32'h9_6000, 32'h20_0000, 32'h20_0000, 32'h1000, "R9 size mismatch");
    send(2'b01, 2'b10, 128, 32'h400, 32'h10_0000, 32'h10_0000, 32'h1000, "R9 minimum granule large");
    // R10 unbind
    send(2'b00, 2'b10, 128, 32'h9_6000, 32'h08_0000, 32'h10_0000, 32'h10_0000, "R10 unbind raised");
    send(2'b00, 2'b10, 128, 32'h9_6000, 32'h08_0000, 32'h10_0000, 32'h8_0000, "R10 aligned to unfenced");
    // R11 reserved mode
    send(2'b10, 2'b11, 1024, 32'h1000, 32'h40, 0, 32'h1000, "R11 reserved mode");
    drain();

    // R12 stall and fill
    bp_mode = 1;
    @(negedge clk);
    send(2'b10, 2'b01, 512, 32'h1000, 0, 0, 32'h1000, "R12 stalled A");
    send(2'b00, 2'b01, 256, 32'h1000, 0, 0, 32'h1000, "R12 stalled B");
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R12 full pipeline blocks input", in_ready, 0);
    check(out_valid == 1'b1, "R12 output waiting", out_valid, 1);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R12 output still waiting", out_valid, 1);
    bp_mode = 0;
    drain();

    // R12 randomized traffic under back-pressure
    bp_mode = 2;
    for (int i = 0; i < 200; i++) begin
      logic [1:0] g, m;
      int unsigned s;
      logic [31:0] sz, off, ps, al;
      g   = 2'($urandom % 4);
      m   = 2'($urandom % 4);
      s   = (32'd1 << ($urandom % 12)) * (1 + $urandom % 3);
      sz  = $urandom % 32'h50_0000;
      off = ($urandom % 8) << (17 + $urandom % 6);
      ps  = 32'd1 << (19 + $urandom % 4);
      al  = 32'd1 << ($urandom % 22);
      send(g, m, s, sz, off, ps, al, "R12 random mix");
    end
    bp_mode = 0;
    drain();

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule